// File: doc/BRIEF.md
# Acquisition Trigger Unit

This block issues a one-cycle trigger pulse for a four-channel sampling front end. A hardware event can come from one of two sources. The first is an external trigger line, which is synchronised and edge-detected. The second is a comparator that watches one chosen sample channel for a crossing of a programmed threshold. Software can also request a trigger by writing to a strobe register. Each of the two paths has its own enable.

The merged event starts a programmable countdown, counted in clock cycles. The pulse leaves when the countdown ends. While a countdown runs, the status flag is high and further events are dropped. The configuration sits behind a small register port that has a combinational read path.

Top module: `trig_unit`

## Requirements
- R1: After reset, trig_o and busy_o are low and every register reads as zero.
- R2: Address 0 holds the configuration word. Its fields are: bit 0 source (0 external line, 1 threshold comparator), bit 1 polarity (0 rising, 1 falling), bit 2 hardware enable, bit 3 software enable, bits 5:4 channel index, and bits 31:16 the unsigned threshold. Bits 15:6 read as zero. Address 1 holds the 32-bit delay. Address 2 and address 3 always read zero. A write takes effect in the cycle after the edge that accepts it.
- R3: The external line passes through two synchronising flops and then an edge detector. Call k the first clock edge that samples the line at its new level. With a delay of 0, a rising change (polarity 0) or a falling change (polarity 1) makes trig_o high for the cycle that follows edge k+2. The opposite change gives no pulse.
- R4: With source 1, an edge that has smp_valid_i high compares the selected channel's new sample with that channel's previous valid sample, both treated as unsigned. Polarity 0 fires when previous < threshold <= new. Polarity 1 fires when previous >= threshold > new. The first valid sample after reset never fires, and unselected channels never fire.
- R5: With hardware enable at 0, no hardware event produces a pulse. With software enable at 0, writes to address 2 produce no pulse.
- R6: A write of any data to address 2 is one software event, accepted on the write edge.
- R7: If an event is accepted on edge e while idle, trig_o is high for the one cycle after edge e+D, where D is the delay. For D > 0, busy_o is high from edge e until edge e+D, and it falls in the cycle where trig_o rises.
- R8: Any event that arrives while busy_o is high is dropped and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_trig_i | input | 1 | External trigger line, asynchronous |
| smp_valid_i | input | 1 | Strobe marking a valid set of samples |
| smp_i | input | 64 | Four 16-bit samples, channel n in bits 16n+15:16n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| trig_o | output | 1 | Delayed trigger pulse |
| busy_o | output | 1 | High while a delay countdown runs |

## Verification
The checker watches several properties on every cycle. It confirms that no pulse appears while busy_o is high and that busy_o only falls together with a pulse. It confirms that an event accepted with a zero delay pulses on the next cycle, that the strobe address reads zero, and that a disabled software strobe leaves the outputs quiet. Other behaviours can only be shown by the bench's scenarios, which compare outputs and read data against a behavioural model on every clock. These are the synchroniser latency and the edge polarity, the crossing direction and the channel choice of the comparator, the field layout of the read back, and the exact position of a delayed pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CH_N     = 4;
  localparam int SMP_W    = 16;
  localparam int DLY_W    = 32;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int CH_SEL_W = $clog2(CH_N);
  localparam int PAD_W    = REG_W - SMP_W - CH_SEL_W - 4;

  localparam logic [ADDR_W-1:0] A_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] A_DLY = 2'd1;
  localparam logic [ADDR_W-1:0] A_SW  = 2'd2;

  typedef struct packed {
    logic [SMP_W-1:0]    thr;
    logic [CH_SEL_W-1:0] ch;
    logic                sw_en;
    logic                hw_en;
    logic                pol;
    logic                src;
  } trig_cfg_t;
endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W,
  parameter int DLW = DLY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output trig_cfg_t     cfg_o,
  output logic [DLW-1:0] dly_o,
  output logic          sw_stb_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CH_LSB = 4;

  trig_cfg_t      cfg_q;
  logic [DLW-1:0] dly_q;
  logic           unused_wbits;

  assign unused_wbits = ^wdata_i[DW-SMP_W-1:CH_LSB+CH_SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      dly_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_CFG) begin
        cfg_q.thr   <= wdata_i[DW-1 -: SMP_W];
        cfg_q.ch    <= wdata_i[CH_LSB +: CH_SEL_W];
        cfg_q.sw_en <= wdata_i[3];
        cfg_q.hw_en <= wdata_i[2];
        cfg_q.pol   <= wdata_i[1];
        cfg_q.src   <= wdata_i[0];
      end else if (addr_i == A_DLY) begin
        dly_q <= wdata_i[DLW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG:   rdata_o = {cfg_q.thr, {PAD_W{1'b0}}, cfg_q.ch,
                          cfg_q.sw_en, cfg_q.hw_en, cfg_q.pol, cfg_q.src};
      A_DLY:   rdata_o = DW'(dly_q);
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign dly_o    = dly_q;
  assign sw_stb_o = we_i && (addr_i == A_SW);
endmodule

// File: rtl/trig_ext_det.sv
module trig_ext_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic pol_i,
  output logic evt_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign evt_o = pol_i ? (~s2_q & s3_q) : (s2_q & ~s3_q);
endmodule

// File: rtl/trig_lvl_det.sv
module trig_lvl_det
  import trig_pkg::*;
#(
  parameter int N  = CH_N,
  parameter int W  = SMP_W,
  parameter int SW = CH_SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [N*W-1:0] smp_i,
  input  logic [SW-1:0] ch_i,
  input  logic [W-1:0]  thr_i,
  input  logic          pol_i,
  output logic          evt_o
);
  logic [N-1:0][W-1:0] cur;
  logic [N-1:0][W-1:0] prev_q;
  logic                primed_q;
  logic [W-1:0]        c_new, c_old;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign cur[g] = smp_i[g*W +: W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (valid_i) begin
      prev_q   <= cur;
      primed_q <= 1'b1;
    end
  end

  assign c_new = cur[ch_i];
  assign c_old = prev_q[ch_i];

  // crossing between consecutive valid samples of the selected channel
  assign evt_o = valid_i && primed_q &&
                 (pol_i ? ((c_old >= thr_i) && (c_new < thr_i))
                        : ((c_old < thr_i) && (c_new >= thr_i)));
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
  parameter int DLW = trig_pkg::DLY_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           evt_i,
  input  logic [DLW-1:0] dly_i,
  output logic           trig_o,
  output logic           busy_o
);
  logic [DLW-1:0] cnt_q;
  logic           busy_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q - DLW'(1);
        if (cnt_q == DLW'(1)) begin
          busy_q <= 1'b0;
          trig_q <= 1'b1;
        end
      end else if (evt_i) begin
        if (dly_i == '0) trig_q <= 1'b1;
        else begin
          busy_q <= 1'b1;
          cnt_q  <= dly_i;
        end
      end
    end
  end

  assign trig_o = trig_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ext_trig_i,
  input  logic                   smp_valid_i,
  input  logic [CH_N*SMP_W-1:0]  smp_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic                   trig_o,
  output logic                   busy_o
);
  trig_cfg_t        cfg;
  logic [DLY_W-1:0] dly;
  logic             sw_stb, ext_evt, lvl_evt, hw_evt, evt;

  trig_regs i_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .dly_o   (dly),
    .sw_stb_o(sw_stb),
    .rdata_o (reg_rdata_o)
  );

  trig_ext_det i_ext (
    .clk_i, .rst_ni,
    .ext_i (ext_trig_i),
    .pol_i (cfg.pol),
    .evt_o (ext_evt)
  );

  trig_lvl_det i_lvl (
    .clk_i, .rst_ni,
    .valid_i (smp_valid_i),
    .smp_i   (smp_i),
    .ch_i    (cfg.ch),
    .thr_i   (cfg.thr),
    .pol_i   (cfg.pol),
    .evt_o   (lvl_evt)
  );

  assign hw_evt = cfg.src ? lvl_evt : ext_evt;
  assign evt    = (cfg.hw_en && hw_evt) || (cfg.sw_en && sw_stb);

  trig_delay i_dly (
    .clk_i, .rst_ni,
    .evt_i  (evt),
    .dly_i  (dly),
    .trig_o (trig_o),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk
  import trig_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              trig_o,
  input logic              busy_o,
  input logic              sw_en_i,
  input logic              hw_en_i,
  input logic              evt_i,
  input logic [DLY_W-1:0]  dly_i
);
  assert_quiet_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !trig_o);

  assert_busy_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> trig_o);

  assert_zero_dly_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && evt_i && dly_i == '0) |=> trig_o);

  assert_sw_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_SW) |-> (reg_rdata_o == '0));

  assert_sw_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_SW && !sw_en_i && !hw_en_i && !busy_o)
      |=> (!trig_o && !busy_o));
endmodule

bind trig_unit trig_unit_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .trig_o      (trig_o),
  .busy_o      (busy_o),
  .sw_en_i     (cfg.sw_en),
  .hw_en_i     (cfg.hw_en),
  .evt_i       (evt),
  .dly_i       (dly)
);

// File: tb/test_trig_unit.sv
`timescale 1ns/1ps
module test_trig_unit;
  logic        clk = 0, rst_n = 0;
  logic        ext = 0, valid = 0, we = 0;
  logic [63:0] smp = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        trig, busy;

  int    errors = 0, checks = 0, pulses = 0;
  bit    done = 0;
  string req = "R1";

  trig_unit i_trig_unit (
    .clk_i(clk), .rst_ni(rst_n), .ext_trig_i(ext), .smp_valid_i(valid),
    .smp_i(smp), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trig_o(trig), .busy_o(busy)
  );

  always #10 clk = ~clk;

  // behavioural reference
  bit          m_src = 0, m_pol = 0, m_hwen = 0, m_swen = 0;
  int          m_ch = 0, m_thr = 0;
  int unsigned m_dly = 0, m_left = 0;
  bit          m_wait = 0, m_pulse = 0, m_primed = 0;
  bit          ext_hist[$];
  int          m_prev[4] = '{0, 0, 0, 0};

  function automatic int chan(input int c);
    return int'(smp[c*16 +: 16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_pol = 0; m_hwen = 0; m_swen = 0; m_ch = 0; m_thr = 0;
      m_dly = 0; m_left = 0; m_wait = 0; m_pulse = 0; m_primed = 0;
      ext_hist = '{0, 0, 0};
      for (int i = 0; i < 4; i++) m_prev[i] = 0;
    end else begin
      bit e_ext, e_lvl, e_sw, ev;
      int nv;
      e_ext = m_pol ? (!ext_hist[1] && ext_hist[2]) : (ext_hist[1] && !ext_hist[2]);
      nv = chan(m_ch);
      e_lvl = valid && m_primed &&
              (m_pol ? (m_prev[m_ch] >= m_thr && nv < m_thr)
                     : (m_prev[m_ch] < m_thr && nv >= m_thr));
      e_sw = we && addr == 2;
      ev = (m_hwen && (m_src ? e_lvl : e_ext)) || (m_swen && e_sw);
      m_pulse = 0;
      if (m_wait) begin
        if (m_left == 1) begin m_pulse = 1; m_wait = 0; end
        m_left--;
      end else if (ev) begin
        if (m_dly == 0) m_pulse = 1;
        else begin m_wait = 1; m_left = m_dly; end
      end
      ext_hist.push_front(ext);
      void'(ext_hist.pop_back());
      if (valid) begin
        for (int i = 0; i < 4; i++) m_prev[i] = chan(i);
        m_primed = 1;
      end
      if (we && addr == 0) begin
        m_src = wdata[0]; m_pol = wdata[1]; m_hwen = wdata[2]; m_swen = wdata[3];
        m_ch = int'(wdata[5:4]); m_thr = int'(wdata[31:16]);
      end else if (we && addr == 1) m_dly = wdata;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    if (a == 0) return {m_thr[15:0], 10'd0, m_ch[1:0], m_swen, m_hwen, m_pol, m_src};
    if (a == 1) return m_dly;
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      checks++;
      if (trig !== m_pulse || busy !== m_wait || rdata !== exp_rd(addr)) begin
        errors++;
        $display("FAIL %s cycle: trig=%b busy=%b rd=%h expected trig=%b busy=%b rd=%h",
                 req, trig, busy, rdata, m_pulse, m_wait, exp_rd(addr));
      end
      if (trig) pulses++;
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input string r, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(r, rdata, exp);
    @(negedge clk); addr = 0;
  endtask

  task automatic sample(input int c, input int v);
    @(negedge clk); smp[c*16 +: 16] = v[15:0]; valid = 1;
    @(negedge clk); valid = 0;
  endtask

  task automatic expect_pulses(input string r, input int n);
    idle(8);
    check(r, pulses, n);
    pulses = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1;
    // R1 reset state
    req = "R1";
    @(negedge clk); #1;
    check("R1 trig", trig, 0);
    check("R1 busy", busy, 0);
    rd("R1 cfg", 0, 0); rd("R1 dly", 1, 0); rd("R1 sw", 2, 0);

    // R2 register layout
    req = "R2";
    wr(0, 32'hFFFF_FFFF); rd("R2 cfg", 0, 32'hFFFF_003F);
    wr(1, 32'hDEAD_BEEF); rd("R2 dly", 1, 32'hDEAD_BEEF);
    rd("R2 sw", 2, 0); rd("R2 unmapped", 3, 0);
    wr(1, 0); wr(0, 0); rd("R2 cleared", 0, 0);
    expect_pulses("R2 no pulse", 0);

    // R3 external line, rising then falling polarity
    req = "R3";
    wr(0, 32'h4);
    idle(2); ext = 1; expect_pulses("R3 rising", 1);
    ext = 0; expect_pulses("R3 rising ignores fall", 0);
    wr(0, 32'h6);
    idle(2); ext = 1; expect_pulses("R3 falling ignores rise", 0);
    ext = 0; expect_pulses("R3 falling", 1);

    // R5 hardware path disabled
    req = "R5";
    wr(0, 32'h0);
    ext = 1; idle(4); ext = 0; expect_pulses("R5 hw off", 0);

    // R6 software strobe, R5 software disable
    req = "R6";
    wr(0, 32'h8); wr(2, 32'h0000_1234); expect_pulses("R6 sw strobe", 1);
    req = "R5";
    wr(0, 32'h0); wr(2, 32'hFFFF_FFFF); expect_pulses("R5 sw off", 0);

    // R4 threshold comparator on channel 2, thr 1000
    req = "R4";
    wr(0, 32'h03E8_0025);
    sample(2, 500); sample(2, 999); expect_pulses("R4 below", 0);
    sample(2, 1000); expect_pulses("R4 rising cross", 1);
    sample(2, 1200); sample(2, 800); expect_pulses("R4 no re-cross up", 0);
    sample(0, 2000); sample(0, 0); sample(0, 2000); expect_pulses("R4 unselected", 0);
    wr(0, 32'h03E8_0027);
    sample(2, 1200); expect_pulses("R4 falling ignores rise", 0);
    sample(2, 999); expect_pulses("R4 falling cross", 1);

    // R7 delay, R8 drop while busy
    req = "R7";
    wr(0, 32'h8); wr(1, 5);
    @(negedge clk); we = 1; addr = 2;
    @(negedge clk); we = 0; addr = 0; #1;
    check("R7 busy during delay", busy, 1);
    req = "R8";
    wr(2, 0); wr(2, 0);
    expect_pulses("R8 single pulse", 1);
    check("R7 busy cleared", busy, 0);
    req = "R7";
    wr(1, 1); wr(2, 0); expect_pulses("R7 delay one", 1);
    wr(1, 0); wr(0, 0);

    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule